// File: doc/BRIEF.md
# Dual-Bank Non-Volatile Image Validator

This block decides which of two copies of a non-volatile settings image may be trusted and which copy is the newer one. After a start pulse it reads both banks byte by byte through a simple read port, with one read per clock. Each bank passes three tests. The signature byte must match. A folded 8-bit header sum must match the stored one. A modulo-65521 running-sum checksum over the body must match the stored 32-bit value. For each bank the block reports a generation number, which is forced to zero when any test fails, and a validity flag. It also reports which bank is active.

A second mode scans one chosen bank and produces the header sum and running-sum checksum for it. Firmware uses these values to stamp an image before writing it back. The header sum in this mode always counts the correct signature value, so the signature byte may still be blank in the staged image. Memory arbitration and the write path are outside this block. The read port expects the addressed byte on `rd_data` one cycle after `rd_en`.

Top module: `nvram_bank_validator`

## Requirements
- R1: After reset, `busy`, `done`, `rd_en`, `active_bank`, `bank_ok`, `gen0`, `gen1`, `calc_hdr_sum` and `calc_adler` are all zero.
- R2: A start accepted with `mode`=0 reads addresses 0 to 2N-1 in ascending order, one per cycle, where N is the bank size and the address MSB selects the bank. The read of offset k is issued in the cycle after the k-th edge that follows the accepting edge. `busy` stays high through edge 2N. `done` is high for exactly the one cycle after edge 2N+1.
- R3: A bank is valid only if its byte 0 equals 0x5A.
- R4: A bank is valid only if its byte 1 equals the header sum. The header sum is computed from 0x5A plus bytes 2 to 15, in a 16-bit sum folded by adding the high byte into the low byte until the result fits in 8 bits.
- R5: A bank is valid only if bytes 0x10 to 0x13 (big-endian) equal (B<<16)|A. Here A = (1 + sum of bytes 0x14 to N-1) mod 65521, and B = (sum of A's running value after each byte) mod 65521.
- R6: A valid bank reports its big-endian generation from bytes 0x14 to 0x17 and sets its `bank_ok` bit. An invalid bank reports generation 0 with its bit cleared.
- R7: `active_bank` becomes 1 when gen0 < gen1, compared unsigned. Otherwise it becomes 0, so ties select bank 0.
- R8: A start with `mode`=1 scans only bank `bank_sel`. `done` follows edge N+1. `calc_hdr_sum` and `calc_adler` are loaded with the header sum, which uses 0x5A regardless of byte 0, and the running-sum checksum of that bank. `gen0`, `gen1`, `bank_ok` and `active_bank` keep their values.
- R9: A validation run leaves `calc_hdr_sum` and `calc_adler` unchanged.
- R10: A start pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| mode | input | 1 | 0 = validate both banks, 1 = compute values for one bank |
| bank_sel | input | 1 | Bank to scan when mode is 1 |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| rd_en | output | 1 | Byte read request |
| rd_addr | output | log2(N)+1 | Byte address, MSB is the bank |
| rd_data | input | 8 | Byte returned one cycle after rd_en |
| gen0 | output | 32 | Generation of bank 0, 0 if invalid |
| gen1 | output | 32 | Generation of bank 1, 0 if invalid |
| bank_ok | output | 2 | Per-bank validity |
| active_bank | output | 1 | Bank holding the newest valid image |
| calc_hdr_sum | output | 8 | Header sum from the last compute run |
| calc_adler | output | 32 | Running-sum checksum from the last compute run |

## Verification
A faulty accumulator or field-capture register shows up only at the end of a bank's scan. It appears as a wrong `bank_ok` bit and a zeroed or wrong generation on the cycle after that bank's last byte is processed, or as a wrong `calc_*` value with `done`. A sequencer fault shows up within a cycle as a skipped or repeated `rd_addr`, or as a `busy`/`done` edge that arrives at the wrong time. The bench builds images in which exactly one layer is broken, and images with all-0xFF bodies that force the modular reduction. It compares every port on every clock against its own model.

// File: rtl/nvv_pkg.sv
package nvv_pkg;

   localparam logic [7:0] NVV_SIG = 8'h5A;

   typedef enum logic {
      NVV_CHECK = 1'b0,
      NVV_CALC  = 1'b1
   } nvv_mode_e;

   // One's-complement style 8-bit add: carry out wraps into bit 0
   function automatic logic [7:0] nvv_eac_add(input logic [7:0] a, input logic [7:0] b);
      logic [8:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[7:0] + {7'd0, s[8]};
   endfunction

endpackage

// File: rtl/nvv_seq.sv
module nvv_seq #(
   parameter int BANK_BYTES = 8192
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic                          mode,
   input  logic                          bank_sel,
   output logic                          rd_en,
   output logic [$clog2(BANK_BYTES):0]   rd_addr,
   output logic                          busy,
   output logic                          p_vld,
   output logic [$clog2(BANK_BYTES)-1:0] p_off,
   output logic                          p_bank,
   output logic                          p_mode
);
   localparam int OW = $clog2(BANK_BYTES);
   localparam logic [OW-1:0] LAST = OW'(BANK_BYTES - 1);

   logic          scan_q;
   logic          more_q;
   logic          bank_q;
   logic [OW-1:0] cnt_q;

   assign rd_en   = scan_q;
   assign rd_addr = {bank_q, cnt_q};
   assign busy    = scan_q | p_vld;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scan_q <= 1'b0;
         more_q <= 1'b0;
         bank_q <= 1'b0;
         cnt_q  <= '0;
         p_vld  <= 1'b0;
         p_off  <= '0;
         p_bank <= 1'b0;
         p_mode <= 1'b0;
      end else begin
         p_vld  <= scan_q;
         p_off  <= cnt_q;
         p_bank <= bank_q;
         if (!scan_q) begin
            if (start && !busy) begin
               scan_q <= 1'b1;
               cnt_q  <= '0;
               bank_q <= mode ? bank_sel : 1'b0;
               more_q <= ~mode;
               p_mode <= mode;
            end
         end else begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
               if (more_q) begin
                  bank_q <= 1'b1;
                  more_q <= 1'b0;
               end else begin
                  scan_q <= 1'b0;
               end
            end
         end
      end
   end

endmodule

// File: rtl/nvv_hdr_sum.sv
module nvv_hdr_sum (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic       add,
   input  logic [7:0] din,
   output logic [7:0] sum
);
   import nvv_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n)    sum <= '0;
      else if (load) sum <= NVV_SIG;
      else if (add)  sum <= nvv_eac_add(sum, din);
   end

endmodule

// File: rtl/nvv_adler.sv
module nvv_adler #(
   parameter int ADLER_MOD = 65521
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        en,
   input  logic        first,
   input  logic [7:0]  din,
   output logic [31:0] nxt
);
   localparam logic [16:0] MODV = 17'(ADLER_MOD);

   logic [15:0] lo_q, hi_q;
   logic [15:0] lo_b, hi_b, lo_n, hi_n;
   logic [16:0] lo_s, hi_s;

   always_comb begin
      lo_b = first ? 16'd1 : lo_q;
      hi_b = first ? 16'd0 : hi_q;
      lo_s = {1'b0, lo_b} + {9'd0, din};
      lo_n = (lo_s >= MODV) ? 16'(lo_s - MODV) : lo_s[15:0];
      hi_s = {1'b0, hi_b} + {1'b0, lo_n};
      hi_n = (hi_s >= MODV) ? 16'(hi_s - MODV) : hi_s[15:0];
      nxt  = {hi_n, lo_n};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q <= 16'd1;
         hi_q <= '0;
      end else if (en) begin
         lo_q <= lo_n;
         hi_q <= hi_n;
      end
   end

endmodule

// File: rtl/nvram_bank_validator.sv
module nvram_bank_validator #(
   parameter int BANK_BYTES = 8192,
   parameter int ADLER_MOD  = 65521
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic                        mode,
   input  logic                        bank_sel,
   output logic                        busy,
   output logic                        done,
   output logic                        rd_en,
   output logic [$clog2(BANK_BYTES):0] rd_addr,
   input  logic [7:0]                  rd_data,
   output logic [31:0]                 gen0,
   output logic [31:0]                 gen1,
   output logic [1:0]                  bank_ok,
   output logic                        active_bank,
   output logic [7:0]                  calc_hdr_sum,
   output logic [31:0]                 calc_adler
);
   import nvv_pkg::*;

   localparam int OW     = $clog2(BANK_BYTES);
   localparam int ADDR_W = OW + 1;
   localparam logic [OW-1:0] OFF_SIG = OW'(0);
   localparam logic [OW-1:0] OFF_CK  = OW'(1);
   localparam logic [OW-1:0] OFF_H0  = OW'(2);
   localparam logic [OW-1:0] OFF_H1  = OW'(15);
   localparam logic [OW-1:0] OFF_ADL = OW'(16);
   localparam logic [OW-1:0] OFF_GEN = OW'(20);
   localparam logic [OW-1:0] LAST    = OW'(BANK_BYTES - 1);

   if (BANK_BYTES < 32 || (BANK_BYTES & (BANK_BYTES - 1)) != 0) begin : g_bad_size
      $error("BANK_BYTES must be a power of two of at least 32");
   end
   if (ADLER_MOD <= 255 || ADLER_MOD >= 65536) begin : g_bad_mod
      $error("ADLER_MOD must lie between 256 and 65535");
   end

   logic          p_vld, p_bank, p_mode;
   logic [OW-1:0] p_off;
   logic [7:0]    hdr_sum;
   logic [31:0]   adl_nxt;
   logic [7:0]    sig_q, ck_q;
   logic [31:0]   adl_q, gen_q;
   logic          fin, fin_chk, fin_calc, ok_now;
   logic [31:0]   gen_val;

   nvv_seq #(.BANK_BYTES(BANK_BYTES)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .bank_sel(bank_sel),
      .rd_en(rd_en), .rd_addr(rd_addr), .busy(busy),
      .p_vld(p_vld), .p_off(p_off), .p_bank(p_bank), .p_mode(p_mode)
   );

   nvv_hdr_sum u_hdr (
      .clk(clk), .rst_n(rst_n),
      .load(p_vld && p_off == OFF_SIG),
      .add(p_vld && p_off >= OFF_H0 && p_off <= OFF_H1),
      .din(rd_data), .sum(hdr_sum)
   );

   nvv_adler #(.ADLER_MOD(ADLER_MOD)) u_adl (
      .clk(clk), .rst_n(rst_n),
      .en(p_vld && p_off >= OFF_GEN),
      .first(p_off == OFF_GEN),
      .din(rd_data), .nxt(adl_nxt)
   );

   // Header field capture, big-endian words
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sig_q <= '0;
         ck_q  <= '0;
         adl_q <= '0;
         gen_q <= '0;
      end else if (p_vld) begin
         if (p_off == OFF_SIG) sig_q <= rd_data;
         if (p_off == OFF_CK)  ck_q  <= rd_data;
         if (p_off[OW-1:2] == OFF_ADL[OW-1:2]) adl_q <= {adl_q[23:0], rd_data};
         if (p_off[OW-1:2] == OFF_GEN[OW-1:2]) gen_q <= {gen_q[23:0], rd_data};
      end
   end

   assign fin      = p_vld && (p_off == LAST);
   assign fin_chk  = fin && (p_mode == NVV_CHECK);
   assign fin_calc = fin && (p_mode == NVV_CALC);
   assign ok_now   = (sig_q == NVV_SIG) && (ck_q == hdr_sum) && (adl_q == adl_nxt);
   assign gen_val  = ok_now ? gen_q : 32'd0;

   for (genvar b = 0; b < 2; b++) begin : g_bank
      logic [31:0] gen_r;
      logic        ok_r;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            gen_r <= '0;
            ok_r  <= 1'b0;
         end else if (fin_chk && (p_bank == 1'(b))) begin
            gen_r <= gen_val;
            ok_r  <= ok_now;
         end
      end
   end

   assign gen0    = g_bank[0].gen_r;
   assign gen1    = g_bank[1].gen_r;
   assign bank_ok = {g_bank[1].ok_r, g_bank[0].ok_r};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done         <= 1'b0;
         active_bank  <= 1'b0;
         calc_hdr_sum <= '0;
         calc_adler   <= '0;
      end else begin
         done <= fin && (p_mode == NVV_CALC || p_bank);
         if (fin_chk && p_bank) active_bank <= (g_bank[0].gen_r < gen_val);
         if (fin_calc) begin
            calc_hdr_sum <= hdr_sum;
            calc_adler   <= adl_nxt;
         end
      end
   end

endmodule

// File: rtl/nvv_checker.sv
module nvv_checker #(
   parameter int AW = 14
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic          rd_en,
   input logic [AW-1:0] rd_addr,
   input logic [31:0]   gen0,
   input logic [31:0]   gen1,
   input logic [1:0]    bank_ok,
   input logic          active_bank
);
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R2
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R2
   AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && $past(rd_en)) |-> rd_addr == AW'($past(rd_addr) + 1'b1)); // R2
   AST_NO_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !rd_en); // R2
   AST_BAD0_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !bank_ok[0] |-> gen0 == 32'd0); // R6
   AST_BAD1_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !bank_ok[1] |-> gen1 == 32'd0); // R6
   AST_ACTIVE_ORDER: assert property (@(posedge clk) disable iff (!rst_n) done |-> active_bank == (gen0 < gen1)); // R7
endmodule

bind nvram_bank_validator nvv_checker #(.AW(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rd_en(rd_en),
   .rd_addr(rd_addr), .gen0(gen0), .gen1(gen1), .bank_ok(bank_ok),
   .active_bank(active_bank)
);

// File: tb/nvram_bank_validator_bench.sv
module nvram_bank_validator_bench;
   localparam int N  = 512;
   localparam int AW = $clog2(N) + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, mode = 1'b0, bank_sel = 1'b0;
   logic busy, done, rd_en, active_bank;
   logic [AW-1:0] rd_addr;
   logic [7:0] rd_data = 8'h00;
   logic [31:0] gen0, gen1, calc_adler;
   logic [1:0] bank_ok;
   logic [7:0] calc_hdr_sum;

   int total = 0, bad = 0;
   bit finished = 0;

   logic [7:0] mem [int];
   logic [31:0] e_gen [2];
   logic        e_ok [2];
   logic        e_act;
   logic [7:0]  e_ch;
   logic [31:0] e_ca;

   always #10 clk = ~clk;

   nvram_bank_validator #(.BANK_BYTES(N)) u_nvram_bank_validator (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .bank_sel(bank_sel),
      .busy(busy), .done(done), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .gen0(gen0), .gen1(gen1), .bank_ok(bank_ok), .active_bank(active_bank),
      .calc_hdr_sum(calc_hdr_sum), .calc_adler(calc_adler)
   );

   function automatic logic [7:0] rdm(int a);
      return mem.exists(a) ? mem[a] : 8'hFF;
   endfunction

   always @(posedge clk) if (rd_en) rd_data <= rdm(int'(rd_addr));

   task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int ref_hdr(int b);
      int s = 'h5A;
      for (int i = 2; i < 16; i++) s += rdm(b * N + i);
      while (s > 255) s = (s & 255) + (s >> 8);
      return s;
   endfunction

   function automatic logic [31:0] ref_adler(int b);
      longint lo = 1, hi = 0;
      for (int i = 'h14; i < N; i++) begin
         lo += rdm(b * N + i);
         hi += lo;
      end
      return {16'(hi % 65521), 16'(lo % 65521)};
   endfunction

   function automatic logic [31:0] word_at(int a);
      return {rdm(a), rdm(a + 1), rdm(a + 2), rdm(a + 3)};
   endfunction

   function automatic bit ref_ok(int b);
      return rdm(b * N) == 8'h5A && rdm(b * N + 1) == 8'(ref_hdr(b))
             && word_at(b * N + 'h10) == ref_adler(b);
   endfunction

   // kind: 0 intact, 1 bad signature, 2 bad header sum, 3 bad body, 4 blank signature
   task automatic build(int b, logic [31:0] g, int seed, int kind);
      int base = b * N;
      for (int i = 2; i < 16; i++) mem[base + i] = 8'((seed + i * 3) & 255);
      for (int i = 'h18; i < N; i++)
         mem[base + i] = (seed < 0) ? 8'hFF : 8'(((i * 13 + seed * 7) ^ (i >> 3)) & 255);
      for (int k = 0; k < 4; k++) mem[base + 'h14 + k] = g[31 - 8 * k -: 8];
      mem[base] = 8'h5A;
      mem[base + 1] = 8'(ref_hdr(b));
      begin
         logic [31:0] a = ref_adler(b);
         for (int k = 0; k < 4; k++) mem[base + 'h10 + k] = a[31 - 8 * k -: 8];
      end
      case (kind)
         1: mem[base] = 8'h5B;
         2: mem[base + 1] = mem[base + 1] ^ 8'h01;
         3: mem[base + 'h100] = mem[base + 'h100] ^ 8'h10;
         4: mem[base] = 8'h00;
         default: ;
      endcase
   endtask

   task automatic check_outputs(string tag);
      chk(gen0 == e_gen[0], {tag, " R6 gen0"}, gen0, e_gen[0]);
      chk(gen1 == e_gen[1], {tag, " R6 gen1"}, gen1, e_gen[1]);
      chk(bank_ok == {e_ok[1], e_ok[0]}, {tag, " R3 R4 R5 bank_ok"}, bank_ok, {e_ok[1], e_ok[0]});
      chk(active_bank == e_act, {tag, " R7 active"}, active_bank, e_act);
      chk(calc_hdr_sum == e_ch, {tag, " R8 R9 calc_hdr"}, calc_hdr_sum, e_ch);
      chk(calc_adler == e_ca, {tag, " R8 R9 calc_adler"}, calc_adler, e_ca);
   endtask

   // Runs one operation and compares every port on every cycle; poke re-pulses start mid-run
   task automatic run_op(bit m, bit sel, bit poke, string tag);
      int L = m ? N : 2 * N;
      int base = m ? (sel ? N : 0) : 0;
      logic [31:0] g0 = ref_ok(0) ? word_at('h14) : 32'd0;
      logic [31:0] g1 = ref_ok(1) ? word_at(N + 'h14) : 32'd0;
      bit o0 = ref_ok(0), o1 = ref_ok(1);
      logic [7:0] ch = 8'(ref_hdr(sel));
      logic [31:0] ca = ref_adler(sel);
      @(negedge clk);
      start = 1'b1; mode = m; bank_sel = sel;
      for (int j = 0; j <= L + 1; j++) begin
         @(negedge clk);
         start = (poke && j == 5);
         mode = ~m;
         if (!m && j == N + 1) begin e_gen[0] = g0; e_ok[0] = o0; end
         if (!m && j == 2 * N + 1) begin e_gen[1] = g1; e_ok[1] = o1; e_act = (e_gen[0] < g1); end
         if (m && j == N + 1) begin e_ch = ch; e_ca = ca; end
         chk(busy == (j <= L), {tag, " R2 R10 busy"}, busy, (j <= L));
         chk(done == (j == L + 1), {tag, " R2 R8 R10 done"}, done, (j == L + 1));
         chk(rd_en == (j < L), {tag, " R2 rd_en"}, rd_en, (j < L));
         if (j < L) chk(rd_addr == AW'(base + j), {tag, " R2 R8 rd_addr"}, rd_addr, AW'(base + j));
         check_outputs(tag);
      end
      start = 1'b0; mode = 1'b0;
   endtask

   initial begin
      e_gen[0] = 0; e_gen[1] = 0; e_ok[0] = 0; e_ok[1] = 0;
      e_act = 0; e_ch = 0; e_ca = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !rd_en, "R1 control idle", {busy, done, rd_en}, 3'b000);
      check_outputs("R1 reset");

      build(0, 32'd5, 1, 0);  build(1, 32'd9, 2, 0);
      run_op(1'b0, 1'b0, 1'b0, "both valid newer bank1 R7");
      build(0, 32'd9, 3, 0);  build(1, 32'd9, 4, 0);
      run_op(1'b0, 1'b0, 1'b0, "tie R7");
      build(0, 32'd2, 5, 0);  build(1, 32'd77, 6, 1);
      run_op(1'b0, 1'b0, 1'b0, "bad signature R3");
      build(0, 32'd500, 7, 2); build(1, 32'd3, -1, 0);
      run_op(1'b0, 1'b0, 1'b0, "bad header sum R4");
      build(0, 32'd4, -1, 0); build(1, 32'd8, 9, 3);
      run_op(1'b0, 1'b0, 1'b0, "bad body R5");
      build(1, 32'd12, 10, 4);
      run_op(1'b1, 1'b1, 1'b1, "compute bank1 blank signature R8 R10");
      build(0, 32'd0, -1, 4);
      run_op(1'b1, 1'b0, 1'b0, "compute bank0 all ones R8");
      build(0, 32'h8000_0000, 11, 0); build(1, 32'h7FFF_FFFF, 12, 0);
      run_op(1'b0, 1'b0, 1'b1, "unsigned order R7 R9 R10");

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog R2 actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule